// File: doc/BRIEF.md
# Byte-Order Configurable Load/Store Lane Steering Unit

This block sits between a 32-bit processor core and its data bus. On a store it places the core's byte, halfword or word on the bus byte lanes and raises one write enable per lane. On a load it picks the addressed byte or halfword out of the bus read word and zero- or sign-extends it to 32 bits. Instruction fetch does not pass through it, so only load and store data follow the selected byte order.

A one-bit configuration register picks the byte order. Value 0 is the native big-endian order and value 1 is the opposite, little-endian order. Software may rewrite the bit at any time, for example when switching to a process that uses the other byte order. The order is not reversed by swapping bytes across the whole word. Instead, the unit XORs the two low address bits with a pattern that depends on the access size, and then selects the lane. The datapath is combinational. Only the configuration bit is clocked.

Top module: `byte_order_lane_unit`

## Requirements
- R1: After the active-low reset `rstN`, the order bit is 0 (native big-endian). In that order a byte access at offset 0 enables lane 3, the lane that carries bits 31:24.
- R2: The order bit takes `cfgWrData` on a rising clock edge where `cfgWrEn` is 1. It keeps its value on every edge where `cfgWrEn` is 0, whatever `cfgWrData` is. It may change between any two accesses.
- R3: For a byte access (`accSize` = 00), exactly one bit of `byteEn` is set. Bit i of `byteEn` covers bus bits 8i+7:8i. In native order the enabled lane is 3 minus the offset. In opposite order it is the offset itself, because the offset is XORed with 11.
- R4: For a halfword access (`accSize` = 01), offset bit 0 is ignored. In native order, offset bit 1 = 0 gives `byteEn` 1100 and offset bit 1 = 1 gives 0011. In opposite order the offset is XORed with 10, so the two results are swapped.
- R5: A word access (`accSize` 10, or the unused code 11, which is treated the same) ignores both offset bits. It gives `byteEn` 1111, `busWrData` equal to `storeData`, and `loadResult` equal to `readData` in both orders. `signExt` has no effect on it.
- R6: Byte store data appears on all four lanes, so `busWrData` = {4{storeData[7:0]}}. Halfword store data appears on both halves, so `busWrData` = {2{storeData[15:0]}}.
- R7: A byte or halfword load returns the selected bus bits. When `signExt` is 0 they are zero-extended to 32 bits. When `signExt` is 1 they are extended from their top bit.
- R8: `misaligned` is 1 for a halfword access with offset bit 0 set and for a word access with a nonzero offset. It is always 0 for byte accesses. It never blocks or changes the access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the configuration bit |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWrEn | input | 1 | Write strobe for the byte-order bit |
| cfgWrData | input | 1 | New byte-order value (0 native, 1 opposite) |
| accOffset | input | 2 | Low two bits of the access address |
| accSize | input | 2 | Access size: 00 byte, 01 halfword, 10 or 11 word |
| signExt | input | 1 | Sign-extend a byte or halfword load result |
| storeData | input | 32 | Store data from the core, right-justified |
| readData | input | 32 | Read word from the data bus |
| busWrData | output | 32 | Store data steered onto the bus lanes |
| byteEn | output | 4 | Per-lane write enables |
| loadResult | output | 32 | Extracted and extended load value |
| misaligned | output | 1 | Offset bits the access size ignores were nonzero |

## Verification
The hardest case to reach is a change of byte order between two accesses that use the same offset and size. The outputs must then follow the new order in the very next access, and a write strobe left low must leave the order unchanged. The stimulus toggles the order bit through the configuration port between the sweeps of offset, size and extension. It also drives the opposite value on `cfgWrData` for a full cycle with the strobe low, then issues a byte access whose lane shows which order is active. Expected values come from a model that lays the bus word out as a four-byte memory in the selected order and reads it back or writes it.

// File: rtl/lane_pkg.sv
`timescale 1ns/1ps
package lane_pkg;
  localparam int LANE_W   = 8;
  localparam int LANE_CNT = 4;
  localparam int DATA_W   = LANE_W * LANE_CNT;
  localparam int OFF_W    = $clog2(LANE_CNT);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WIDE = 2'b11
  } accSize_e;

  // strobes from control to datapath
  typedef struct packed {
    logic [OFF_W-1:0] laneIdx;   // byte: the lane; half: low lane of the pair
    logic             isByte;
    logic             isHalf;
    logic             signExt;
  } laneStrobes_t;
endpackage

// File: rtl/order_cfg_reg.sv
`timescale 1ns/1ps
module order_cfg_reg #(
  parameter logic RESET_ORDER = 1'b0
) (
  input  logic clk,
  input  logic rstN,
  input  logic wrEn,
  input  logic wrData,
  output logic orderMode
);
  always_ff @(posedge clk) begin
    if (!rstN)     orderMode <= RESET_ORDER;
    else if (wrEn) orderMode <= wrData;
  end
endmodule

// File: rtl/lane_ctrl.sv
`timescale 1ns/1ps
module lane_ctrl
  import lane_pkg::*;
#(
  parameter bit UNIFORM_XOR = 1'b0
) (
  input  logic [OFF_W-1:0]    accOffset,
  input  logic [1:0]          accSize,
  input  logic                signExt,
  input  logic                orderMode,
  output laneStrobes_t        strobes,
  output logic [LANE_CNT-1:0] byteEn,
  output logic                misaligned
);
  logic             isByte, isHalf, isWord;
  logic [OFF_W-1:0] alignMask, flipPat, effOff, laneIdx;

  always_comb begin
    isByte    = (accSize == SZ_BYTE);
    isHalf    = (accSize == SZ_HALF);
    isWord    = !isByte && !isHalf;
    alignMask = isByte ? 2'b11 : (isHalf ? 2'b10 : 2'b00);
  end

  generate
    if (UNIFORM_XOR) begin : g_uniform
      // flip both bits for every size, then clear the ignored bits
      always_comb begin
        flipPat = orderMode ? 2'b11 : 2'b00;
        effOff  = (accOffset ^ flipPat) & alignMask;
      end
    end else begin : g_sized
      // align first, then flip with a size-dependent pattern
      always_comb begin
        flipPat = orderMode ? alignMask : 2'b00;
        effOff  = (accOffset & alignMask) ^ flipPat;
      end
    end
  endgenerate

  // native order is big-endian: offset 0 lives in the top lane
  always_comb begin
    laneIdx = isByte ? ~effOff : {~effOff[1], 1'b0};
    strobes.laneIdx = laneIdx;
    strobes.isByte  = isByte;
    strobes.isHalf  = isHalf;
    strobes.signExt = signExt;
    misaligned      = (isHalf && accOffset[0]) || (isWord && (accOffset != '0));
  end

  generate
    for (genvar i = 0; i < LANE_CNT; i++) begin : g_en
      localparam logic [OFF_W-1:0] LaneNum = OFF_W'(i);
      assign byteEn[i] = isByte ? (laneIdx == LaneNum)
                       : isHalf ? (laneIdx[1] == LaneNum[1])
                       : 1'b1;
    end
  endgenerate
endmodule

// File: rtl/lane_datapath.sv
`timescale 1ns/1ps
module lane_datapath
  import lane_pkg::*;
(
  input  laneStrobes_t      strobes,
  input  logic [DATA_W-1:0] storeData,
  input  logic [DATA_W-1:0] readData,
  output logic [DATA_W-1:0] busWrData,
  output logic [DATA_W-1:0] loadResult
);
  localparam int HALF_W = DATA_W / 2;

  logic [LANE_W-1:0] laneBytes [LANE_CNT];
  logic [LANE_W-1:0] pickedByte;
  logic [HALF_W-1:0] pickedHalf;

  generate
    for (genvar i = 0; i < LANE_CNT; i++) begin : g_lane
      assign laneBytes[i] = readData[i*LANE_W +: LANE_W];
    end
  endgenerate

  always_comb begin
    pickedByte = laneBytes[strobes.laneIdx];
    pickedHalf = strobes.laneIdx[1] ? readData[DATA_W-1:HALF_W] : readData[HALF_W-1:0];

    if (strobes.isByte) begin
      busWrData  = {LANE_CNT{storeData[LANE_W-1:0]}};
      loadResult = {{(DATA_W-LANE_W){strobes.signExt & pickedByte[LANE_W-1]}}, pickedByte};
    end else if (strobes.isHalf) begin
      busWrData  = {2{storeData[HALF_W-1:0]}};
      loadResult = {{(DATA_W-HALF_W){strobes.signExt & pickedHalf[HALF_W-1]}}, pickedHalf};
    end else begin
      busWrData  = storeData;
      loadResult = readData;
    end
  end
endmodule

// File: rtl/byte_order_lane_unit.sv
`timescale 1ns/1ps
module byte_order_lane_unit #(
  parameter bit UNIFORM_XOR = 1'b0
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        cfgWrEn,
  input  logic        cfgWrData,
  input  logic [1:0]  accOffset,
  input  logic [1:0]  accSize,
  input  logic        signExt,
  input  logic [31:0] storeData,
  input  logic [31:0] readData,
  output logic [31:0] busWrData,
  output logic [3:0]  byteEn,
  output logic [31:0] loadResult,
  output logic        misaligned
);
  import lane_pkg::*;

  logic         orderMode;
  laneStrobes_t strobes;

  order_cfg_reg #(.RESET_ORDER(1'b0)) u_cfg (
    .clk(clk), .rstN(rstN), .wrEn(cfgWrEn), .wrData(cfgWrData), .orderMode(orderMode)
  );

  lane_ctrl #(.UNIFORM_XOR(UNIFORM_XOR)) u_ctrl (
    .accOffset(accOffset), .accSize(accSize), .signExt(signExt), .orderMode(orderMode),
    .strobes(strobes), .byteEn(byteEn), .misaligned(misaligned)
  );

  lane_datapath u_dp (
    .strobes(strobes), .storeData(storeData), .readData(readData),
    .busWrData(busWrData), .loadResult(loadResult)
  );
endmodule

// File: rtl/lane_unit_checker.sv
`timescale 1ns/1ps
module lane_unit_checker (
  input logic        clk,
  input logic        rstN,
  input logic        cfgWrEn,
  input logic        cfgWrData,
  input logic        orderMode,
  input logic [1:0]  accOffset,
  input logic [1:0]  accSize,
  input logic        signExt,
  input logic [31:0] storeData,
  input logic [31:0] readData,
  input logic [31:0] busWrData,
  input logic [3:0]  byteEn,
  input logic [31:0] loadResult,
  input logic        misaligned
);
  a_r1_reset_native: assert property (@(posedge clk) $rose(rstN) |-> orderMode == 1'b0);

  a_r2_write_takes: assert property (@(posedge clk) disable iff (!rstN)
    cfgWrEn |=> orderMode == $past(cfgWrData));

  a_r2_hold_without_strobe: assert property (@(posedge clk) disable iff (!rstN)
    !cfgWrEn |=> $stable(orderMode));

  a_r3_single_lane: assert property (@(posedge clk) disable iff (!rstN)
    accSize == 2'b00 |-> $countones(byteEn) == 1);

  a_r4_lane_pair: assert property (@(posedge clk) disable iff (!rstN)
    accSize == 2'b01 |-> (byteEn == 4'b1100 || byteEn == 4'b0011));

  a_r5_word_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    accSize[1] |-> (byteEn == 4'hF && busWrData == storeData && loadResult == readData));

  a_r6_byte_replicated: assert property (@(posedge clk) disable iff (!rstN)
    accSize == 2'b00 |-> busWrData == {4{storeData[7:0]}});

  a_r7_zero_extend: assert property (@(posedge clk) disable iff (!rstN)
    (accSize == 2'b00 && !signExt) |-> loadResult[31:8] == 24'h0);

  a_r8_byte_never_misaligned: assert property (@(posedge clk) disable iff (!rstN)
    accSize == 2'b00 |-> !misaligned);
endmodule

bind byte_order_lane_unit lane_unit_checker u_lane_chk (
  .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .orderMode(orderMode),
  .accOffset(accOffset), .accSize(accSize), .signExt(signExt), .storeData(storeData),
  .readData(readData), .busWrData(busWrData), .byteEn(byteEn), .loadResult(loadResult),
  .misaligned(misaligned)
);

// File: tb/test_byte_order_lane_unit.sv
`timescale 1ns/1ps
module test_byte_order_lane_unit;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cfgWrEn = 1'b0, cfgWrData = 1'b0;
  logic [1:0]  accOffset = '0, accSize = '0;
  logic        signExt = 1'b0;
  logic [31:0] storeData = '0, readData = '0;
  logic [31:0] busWrData, loadResult;
  logic [3:0]  byteEn;
  logic        misaligned;

  always #2 clk = ~clk;   // 250 MHz

  byte_order_lane_unit i_byte_order_lane_unit (
    .clk(clk), .rstN(rstN), .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData),
    .accOffset(accOffset), .accSize(accSize), .signExt(signExt),
    .storeData(storeData), .readData(readData), .busWrData(busWrData),
    .byteEn(byteEn), .loadResult(loadResult), .misaligned(misaligned)
  );

  typedef struct {
    logic [3:0]  en;
    logic [31:0] wr;
    logic [31:0] ld;
    logic        mis;
    string       tagEn, tagWr, tagLd;
  } exp_t;

  exp_t sbQ[$];
  event itemReady;
  int   checks = 0, fails = 0;
  bit   benchMode = 1'b0;
  bit   done = 1'b0;

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // reference: the bus word viewed as four bytes of memory in the chosen order
  function automatic exp_t model(bit mode, int sz, int off, bit sx,
                                 logic [31:0] sd, logic [31:0] rd);
    exp_t e;
    logic [7:0]  mem [4];
    logic [31:0] val;
    int n, base;
    for (int k = 0; k < 4; k++) mem[k] = mode ? rd[8*k +: 8] : rd[8*(3-k) +: 8];
    n    = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    base = (sz == 0) ? off : (sz == 1) ? (off & 2) : 0;
    val  = '0;
    for (int i = 0; i < n; i++) begin
      if (!mode) val = (val << 8) | 32'(mem[base+i]);
      else       val = val | (32'(mem[base+i]) << (8*i));
    end
    if (n == 1 && sx && val[7])  val = val | 32'hFFFF_FF00;
    if (n == 2 && sx && val[15]) val = val | 32'hFFFF_0000;
    e.ld = val;
    e.wr = (n == 1) ? {4{sd[7:0]}} : (n == 2) ? {2{sd[15:0]}} : sd;
    e.en = '0;
    for (int i = 0; i < n; i++) begin
      int k, lane;
      k    = base + i;
      lane = mode ? k : 3 - k;
      e.en[lane] = 1'b1;
      e.wr[8*lane +: 8] = mode ? sd[8*i +: 8] : sd[8*(n-1-i) +: 8];
    end
    e.mis   = (sz == 1) ? (off[0] == 1'b1) : (sz >= 2) ? (off != 0) : 1'b0;
    e.tagEn = (sz == 0) ? "R3" : (sz == 1) ? "R4" : "R5";
    e.tagWr = (sz < 2) ? "R6" : "R5";
    e.tagLd = (sz < 2) ? "R7" : "R5";
    return e;
  endfunction

  task automatic setMode(bit m);
    @(negedge clk); cfgWrEn = 1'b1; cfgWrData = m;
    @(negedge clk); cfgWrEn = 1'b0;
    benchMode = m;
  endtask

  task automatic drive(int sz, int off, bit sx, logic [31:0] sd, logic [31:0] rd);
    @(negedge clk);
    accSize = 2'(sz); accOffset = 2'(off); signExt = sx; storeData = sd; readData = rd;
    sbQ.push_back(model(benchMode, sz, off, sx, sd, rd));
    -> itemReady;
  endtask

  // monitor
  initial begin
    forever begin
      exp_t e;
      @(itemReady);
      #1;
      e = sbQ.pop_front();
      check(e.tagEn, "byteEn", 32'(byteEn), 32'(e.en));
      check(e.tagWr, "busWrData", busWrData, e.wr);
      check(e.tagLd, "loadResult", loadResult, e.ld);
      check("R8", "misaligned", 32'(misaligned), 32'(e.mis));
    end
  end

  // watchdog
  initial begin
    #(4 * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] rdPat [3];
    logic [31:0] sdPat [3];
    rdPat[0] = 32'hF182_7394; rdPat[1] = 32'h1A2B_3C4D; rdPat[2] = 32'h80FF_7F01;
    sdPat[0] = 32'hA5C3_96E1; sdPat[1] = 32'h0123_4567; sdPat[2] = 32'hFEDC_BA98;

    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1: reset order is native; byte at offset 0 uses lane 3
    @(negedge clk);
    accSize = 2'b00; accOffset = 2'b00; storeData = 32'h0; readData = 32'hC0DE_0000;
    #1;
    check("R1", "byteEn after reset", 32'(byteEn), 32'h8);
    check("R1", "loadResult after reset", loadResult, 32'h0000_00C0);

    // full sweep, order changed between sweeps
    for (int m = 0; m < 2; m++) begin
      setMode(m[0]);
      for (int p = 0; p < 3; p++)
        for (int sz = 0; sz < 4; sz++)
          for (int off = 0; off < 4; off++)
            for (int sx = 0; sx < 2; sx++)
              drive(sz, off, sx[0], sdPat[p], rdPat[p]);
    end

    // R2: strobe low with opposite data leaves order unchanged (currently 1)
    @(negedge clk); cfgWrEn = 1'b0; cfgWrData = 1'b0;
    @(negedge clk);
    accSize = 2'b00; accOffset = 2'b00; signExt = 1'b0; readData = 32'h1122_3344;
    #1;
    check("R2", "byteEn with strobe low", 32'(byteEn), 32'h1);
    check("R2", "loadResult with strobe low", loadResult, 32'h0000_0044);

    // R2: order switched back mid-stream, same access follows at once
    setMode(1'b0);
    drive(0, 0, 1'b0, 32'h0, 32'h1122_3344);
    drive(1, 2, 1'b1, 32'h0000_BEEF, 32'h1122_8344);
    setMode(1'b1);
    drive(1, 2, 1'b1, 32'h0000_BEEF, 32'h1122_8344);
    drive(0, 3, 1'b1, 32'h0000_0077, 32'h9122_3344);

    repeat (3) @(negedge clk);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule